// File: doc/BRIEF.md
# Synchronous FIFO with Reset-Recovery Guard

A single-clock first-in first-out buffer whose full flag doubles as a busy indicator. Full is high throughout reset and for a fixed number of clock edges after reset is released. Because every write is gated by full, a producer that respects the flag cannot lose a word while the buffer is still settling. Empty is held high over the same window, so a consumer also waits.

The write side follows stream rules with back-pressure. `wr_valid` offers `wr_data`, and `full` is the inverse of ready. A word is taken on a rising edge where `wr_valid` is high and `full` is low. An offer made while `full` is high is dropped and is not retried. The read side works the same way. `rd_req` pulls a word on an edge where `empty` is low. The word appears on the registered `rd_data` after that edge and stays there until the next accepted read.

Data width, address width (depth is two to the power of the address width) and recovery length are parameters. Occupancy is tracked with read and write pointers that each carry one extra wrap bit.

Top module: `sfg_fifo`

## Requirements
- R1: While `rst` is high, both `full` and `empty` read as 1.
- R2: After `rst` falls, `full` stays 1 after the first and second rising edges and reads 0 after the third (RECOVER=3). This timing is the same for every data width and does not depend on the clock period.
- R3: An offer made while `full` is 1 is discarded. This covers offers during reset, during the recovery window and while the buffer holds DEPTH words. A discarded word never appears on `rd_data`.
- R4: A word is stored on a rising edge where `wr_valid` is 1 and `full` is 0.
- R5: Words are read back in exactly the order they were accepted. A word written on the first edge where `full` is 0 after recovery is the first word read.
- R6: A read is honoured only on an edge where `rd_req` is 1 and `empty` is 0. `rd_data` changes on that edge and holds its value on every other edge.
- R7: A read and a write accepted on the same edge, while the buffer is neither full nor empty, leave the occupancy unchanged.
- R8: `full` is 1 when the occupancy equals DEPTH, and `empty` is 1 when the occupancy is 0 (outside the recovery window).
- R9: Asserting `rst` during operation discards all stored words. After recovery the buffer is empty and not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write offer |
| wr_data | input | WIDTH | Word offered for writing |
| full | output | 1 | No room, or reset/recovery in progress (inverse of write ready) |
| rd_req | input | 1 | Read request |
| rd_data | output | WIDTH | Registered read word |
| empty | output | 1 | Nothing to read, or reset/recovery in progress |

## Verification
`full` and `empty` are combinational from registered state, so they settle right after the edge that changes occupancy or the recovery counter. The bench therefore reads them 1 ns after each edge and counts the edges after reset release one by one. `rd_data` is due one edge after an accepted read, so each read check samples just after that edge and compares against a queue the bench keeps of accepted words. Holds and drops are checked at the same point, one edge after the ignored request and before the next request.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  // width of a counter that must reach the value n
  function automatic int cnt_w(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sfg_recovery_guard.sv
module sfg_recovery_guard #(
  parameter int RECOVER = 3
) (
  input  logic clk,
  input  logic rst,
  output logic busy
);
  generate
    if (RECOVER == 0) begin : g_none
      assign busy = rst;
    end else begin : g_cnt
      localparam int CW = sfg_pkg::cnt_w(RECOVER);
      localparam logic [CW-1:0] LIMIT = CW'(RECOVER);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
      end

      assign busy = rst | (cnt != LIMIT);

      // once recovered, stays recovered until the next reset
      assert_stay_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !busy);
    end
  endgenerate
endmodule

// File: rtl/sfg_ptr_ctrl.sv
module sfg_ptr_ctrl #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              wr_req,
  input  logic              rd_req,
  output logic              wr_go,
  output logic              rd_go,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              full,
  output logic              empty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);

  logic [ADDR_W:0] wptr, rptr, occ;

  assign occ   = wptr - rptr;
  assign full  = hold | (occ == DEPTH_V);
  assign empty = hold | (occ == '0);
  assign wr_go = wr_req & ~full;
  assign rd_go = rd_req & ~empty;
  assign wr_addr = wptr[ADDR_W-1:0];
  assign rd_addr = rptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_go) wptr <= wptr + 1'b1;
      if (rd_go) rptr <= rptr + 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    full |=> $stable(wptr));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    empty |=> $stable(rptr));
  assert_occ_bound_R8: assert property (@(posedge clk) disable iff (rst)
    occ <= DEPTH_V);
  assert_rw_balance_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_go && rd_go) |=> (occ == $past(occ)));
endmodule

// File: rtl/sfg_store.sv
module sfg_store #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  assert_hold_data_R6: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));
endmodule

// File: rtl/sfg_fifo.sv
module sfg_fifo #(
  parameter int WIDTH   = 8,
  parameter int ADDR_W  = 3,
  parameter int RECOVER = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             rd_req,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty
);
  logic              busy, wr_go, rd_go;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  sfg_recovery_guard #(.RECOVER(RECOVER)) u_guard (
    .clk(clk), .rst(rst), .busy(busy)
  );

  sfg_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .hold(busy),
    .wr_req(wr_valid), .rd_req(rd_req),
    .wr_go(wr_go), .rd_go(rd_go),
    .wr_addr(wr_addr), .rd_addr(rd_addr),
    .full(full), .empty(empty)
  );

  sfg_store #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_go), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_go), .raddr(rd_addr), .rdata(rd_data)
  );

  always_comb begin
    if (rst == 1'b1) begin
      assert_full_in_reset_R1: assert (full && empty);
    end
  end

  generate
    if (RECOVER > 0) begin : g_chk
      assert_guard_after_release_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (full && empty));
    end
  endgenerate
endmodule

// File: tb/test_sfg_fifo.sv
module test_sfg_fifo;
  localparam int W = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic rd_req = 1'b0;
  logic full, empty;
  logic [W-1:0] rd_data;
  logic full_w, empty_w;
  logic [19:0] rd_data_w;

  int total = 0;
  int bad = 0;
  logic [W-1:0] q[$];

  always #5 clk = ~clk;

  sfg_fifo #(.WIDTH(W), .ADDR_W(AW), .RECOVER(3)) i_sfg_fifo (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .full(full),
    .rd_req(rd_req), .rd_data(rd_data), .empty(empty)
  );

  // wider instance: recovery timing must match
  sfg_fifo #(.WIDTH(20), .ADDR_W(AW), .RECOVER(3)) i_sfg_fifo_wide (
    .clk(clk), .rst(rst), .wr_valid(1'b0), .wr_data(20'h0), .full(full_w),
    .rd_req(1'b0), .rd_data(rd_data_w), .empty(empty_w)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr1(logic [W-1:0] d);
    wr_valid = 1'b1;
    wr_data = d;
    if (!full) q.push_back(d);
    cyc();
    wr_valid = 1'b0;
  endtask

  task automatic rd1(string tag);
    logic [W-1:0] e;
    rd_req = 1'b1;
    e = q.pop_front();
    cyc();
    rd_req = 1'b0;
    chk(tag, rd_data, e);
  endtask

  task automatic t_reset_window();
    rst = 1'b1;
    cyc(); cyc(); cyc();
    chk("R1 full in reset", full, 1);
    chk("R1 empty in reset", empty, 1);
    chk("R1 wide full in reset", full_w, 1);
    chk("R6 rd_data after reset", rd_data, 0);
    rst = 1'b0;
    wr_valid = 1'b1;
    wr_data = 8'hAA;
    cyc();
    chk("R2 full edge1", full, 1);
    chk("R2 wide full edge1", full_w, 1);
    cyc();
    chk("R2 full edge2", full, 1);
    chk("R2 empty edge2", empty, 1);
    cyc();
    chk("R2 full edge3", full, 0);
    chk("R2 wide full edge3", full_w, 0);
    chk("R3 window writes dropped", empty, 1);
    wr_data = 8'h11;
    cyc();
    wr_valid = 1'b0;
    chk("R4 first write accepted", empty, 0);
    rd_req = 1'b1;
    cyc();
    rd_req = 1'b0;
    chk("R5 first word read first", rd_data, 8'h11);
    chk("R3 no dropped word stored", empty, 1);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      chk("R8 not full before depth", full, 0);
      wr1(8'h40 + 8'(i));
    end
    chk("R8 full at depth", full, 1);
    wr1(8'hEE);
    chk("R3 still full after dropped write", full, 1);
    for (int i = 0; i < DEPTH; i++) rd1("R5 fill order");
    chk("R8 empty after drain", empty, 1);
    chk("R3 dropped word absent", q.size(), 0);
    rd_req = 1'b1;
    cyc();
    rd_req = 1'b0;
    chk("R6 read while empty ignored", rd_data, 8'h47);
    cyc();
    chk("R6 rd_data held when idle", rd_data, 8'h47);
  endtask

  task automatic t_simul();
    logic [W-1:0] e;
    for (int i = 0; i < 3; i++) wr1(8'h10 + 8'(i));
    for (int i = 0; i < 5; i++) begin
      wr_valid = 1'b1;
      wr_data = 8'h20 + 8'(i);
      rd_req = 1'b1;
      q.push_back(wr_data);
      e = q.pop_front();
      cyc();
      chk("R7 simultaneous read data", rd_data, e);
    end
    wr_valid = 1'b0;
    rd_req = 1'b0;
    for (int i = 0; i < DEPTH - 3; i++) begin
      chk("R7 occupancy unchanged", full, 0);
      wr1(8'h60 + 8'(i));
    end
    chk("R7 full after remaining room", full, 1);
    while (q.size() > 0) rd1("R5 order after mixed traffic");
    chk("R8 empty after mixed drain", empty, 1);
  endtask

  task automatic t_midreset();
    wr1(8'h77);
    wr1(8'h78);
    rst = 1'b1;
    cyc();
    chk("R1 full on mid reset", full, 1);
    chk("R1 empty on mid reset", empty, 1);
    rst = 1'b0;
    q.delete();
    cyc(); cyc(); cyc();
    chk("R9 not full after recovery", full, 0);
    chk("R9 contents discarded", empty, 1);
    wr1(8'h99);
    rd1("R9 fresh word after reset");
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset_window();
    t_fill();
    t_simul();
    t_midreset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule